// File: doc/BRIEF.md
# Frame-Match Interrupt Controller

This block is the interrupt and frame-timing register set of an audio serial port. It collects eight interrupt sources. Seven of them arrive as single-cycle event strobes from the rest of the port. The eighth is raised internally when a 32-bit frame counter, advanced by a frame strobe, reaches a programmed match value. Each source owns two adjacent bits in one 32-bit control word: an enable and a sticky pending flag. The block drives a single level-sensitive interrupt line.

Software reaches the block over a simple register bus. A request carries a valid, a write flag, a byte address and write data. Reads return data one cycle later, qualified by a read-valid strobe. Three registers are mapped: the control word, the frame counter, which is loadable, and the frame match value. A typical driver programs the match value, enables the frame source, and clears its pending bit from the interrupt handler by writing a one back to it.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset, the control word, the frame counter and the frame match value are zero, and `irq` is low.
- R2: Control word layout: source pairs fill bits 31..16, with the enable in the upper bit of each pair and the pending flag in the lower bit. From the top the pairs are: frame match 31/30, message 29/28, new peak 27/26, clocks stopped 25/24, sync error 23/22, sync good 21/20, new sample rate 19/18, status 17/16. Strobe `evt_in[k]` drives the pair at bits 17+2k/16+2k, for k = 0 to 6.
- R3: A strobe sets its pending flag at the next clock edge, whether or not the source is enabled.
- R4: A control write loads every enable bit from the write data. A one in a pending position clears that flag, and a zero there leaves it unchanged.
- R5: When a strobe and a write-one-to-clear hit the same pending flag in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when at least one source has both its enable and its pending flag set. It follows the register state from the edge that changed that state.
- R7: Bits 15..0 of the control word always read as zero, whatever is written to them.
- R8: The frame counter adds one on each `frame_tick`, wraps from 0xFFFFFFFF to 0, and is loaded by a write to 0x40. A load in the same cycle as a tick takes precedence, and the tick is lost.
- R9: The frame-match pending flag (bit 30) sets when a tick advances the counter to a value equal to the match register (0x50). A load through the bus never raises it.
- R10: A read returns data in the cycle after the request, with `rd_valid` high for that one cycle. The map is 0x00 control, 0x40 counter, 0x50 match. Any other address reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data, zero when not valid |
| evt_in | input | 7 | Single-cycle source strobes, bit k maps to pair 17+2k/16+2k |
| frame_tick | input | 1 | Frame strobe advancing the counter |
| irq | output | 1 | Level interrupt output |

## Verification
A wrong enable or pending flag shows on `irq` in the very next cycle whenever the partner bit of its pair is set. In every case it appears in the next control-word read, so a corrupted pair is visible within two cycles of the read request. A counter that skips or double-counts shows up in the next counter read. Its effect on the match flag appears only when the programmed value is crossed, so the bench drives the counter through the match and through the wrap. A strobe mapped to the wrong pair appears as a wrong bit in the control word the cycle after it is read back.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned NUM_SRC   = 8;
    localparam int unsigned EXT_SRC   = NUM_SRC - 1;
    localparam int unsigned SRC_BASE  = 16;
    localparam int unsigned FRAME_SRC = NUM_SRC - 1;

    localparam int unsigned OFS_CTL   = 'h00;
    localparam int unsigned OFS_CNT   = 'h40;
    localparam int unsigned OFS_MATCH = 'h50;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CTL   = 2'd1,
        SEL_CNT   = 2'd2,
        SEL_MATCH = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/fic_frame_counter.sv
module fic_frame_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_cnt,
    input  logic             load_match,
    input  logic [CNT_W-1:0] wval,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] match,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] match;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] inc_val;
    logic             hit_d;

    always_comb begin
        st_d    = st_q;
        inc_val = st_q.count + CNT_W'(1);
        hit_d   = 1'b0;
        if (load_cnt) begin
            st_d.count = wval;
        end else if (tick) begin
            st_d.count = inc_val;
            hit_d      = (inc_val == st_q.match);
        end
        if (load_match) begin
            st_d.match = wval;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.count;
    assign match = st_q.match;
    assign hit   = hit_d;
endmodule

// File: rtl/fic_src_bank.sv
module fic_src_bank #(
    parameter int unsigned N_SRC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_in,
    input  logic             wr_ctl,
    input  logic [N_SRC-1:0] wr_en,
    input  logic [N_SRC-1:0] wr_clr,
    output logic [N_SRC-1:0] en,
    output logic [N_SRC-1:0] pend
);
    typedef struct packed {
        logic [N_SRC-1:0] en;
        logic [N_SRC-1:0] pend;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.en   = wr_en;
            st_d.pend = st_q.pend & ~wr_clr;
        end
        // a strobe overrides a clear in the same cycle
        st_d.pend = st_d.pend | set_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign pend = st_q.pend;
endmodule

// File: rtl/fic_bus_if.sv
module fic_bus_if #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] ctl_word,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [CNT_W-1:0]  match_val,
    output logic              wr_ctl,
    output logic              wr_cnt,
    output logic              wr_match,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import fic_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(OFS_MATCH);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    reg_sel_e  sel;
    logic      do_wr, do_rd;

    always_comb begin
        unique case (req_addr)
            A_CTL:   sel = SEL_CTL;
            A_CNT:   sel = SEL_CNT;
            A_MATCH: sel = SEL_MATCH;
            default: sel = SEL_NONE;
        endcase
        do_wr = req_valid && req_write;
        do_rd = req_valid && !req_write;

        wr_ctl   = do_wr && (sel == SEL_CTL);
        wr_cnt   = do_wr && (sel == SEL_CNT);
        wr_match = do_wr && (sel == SEL_MATCH);

        rd_d.valid = do_rd;
        rd_d.data  = '0;
        if (do_rd) begin
            unique case (sel)
                SEL_CTL:   rd_d.data = ctl_word;
                SEL_CNT:   rd_d.data = DATA_W'(cnt_val);
                SEL_MATCH: rd_d.data = DATA_W'(match_val);
                default:   rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;
endmodule

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [fic_pkg::DATA_W-1:0]    req_wdata,
    output logic                          rd_valid,
    output logic [fic_pkg::DATA_W-1:0]    rd_data,
    input  logic [fic_pkg::EXT_SRC-1:0]   evt_in,
    input  logic                          frame_tick,
    output logic                          irq
);
    import fic_pkg::*;

    localparam int unsigned PAIR_TOP = SRC_BASE + 2 * NUM_SRC;

    logic [NUM_SRC-1:0] en_q, pend_q, set_vec, wen_vec, wclr_vec;
    logic [DATA_W-1:0]  ctl_word;
    logic [CNT_W-1:0]   count_q, match_q;
    logic               frame_hit, wr_ctl, wr_cnt, wr_match;

    assign set_vec = {frame_hit, evt_in};

    assign ctl_word[SRC_BASE-1:0] = '0;
    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_pair
            assign wen_vec[k]                  = req_wdata[SRC_BASE + 2*k + 1];
            assign wclr_vec[k]                 = req_wdata[SRC_BASE + 2*k];
            assign ctl_word[SRC_BASE + 2*k + 1] = en_q[k];
            assign ctl_word[SRC_BASE + 2*k]     = pend_q[k];
        end
        if (PAIR_TOP < DATA_W) begin : g_upper
            assign ctl_word[DATA_W-1:PAIR_TOP] = '0;
        end
    endgenerate

    fic_bus_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .ctl_word  (ctl_word),
        .cnt_val   (count_q),
        .match_val (match_q),
        .wr_ctl    (wr_ctl),
        .wr_cnt    (wr_cnt),
        .wr_match  (wr_match),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    fic_frame_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (frame_tick),
        .load_cnt   (wr_cnt),
        .load_match (wr_match),
        .wval       (req_wdata[CNT_W-1:0]),
        .count      (count_q),
        .match      (match_q),
        .hit        (frame_hit)
    );

    fic_src_bank #(.N_SRC(NUM_SRC)) i_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (set_vec),
        .wr_ctl (wr_ctl),
        .wr_en  (wen_vec),
        .wr_clr (wclr_vec),
        .en     (en_q),
        .pend   (pend_q)
    );

    assign irq = |(en_q & pend_q);
endmodule

// File: rtl/frame_irq_chk.sv
module frame_irq_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic                        req_write,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [fic_pkg::EXT_SRC-1:0] evt_in,
    input logic                        frame_tick,
    input logic                        irq,
    input logic                        rd_valid,
    input logic [fic_pkg::DATA_W-1:0]  rd_data,
    input logic [fic_pkg::NUM_SRC-1:0] pend,
    input logic [CNT_W-1:0]            count
);
    import fic_pkg::*;

    logic cnt_load;
    assign cnt_load = req_valid && req_write && (req_addr == ADDR_W'(OFS_CNT));

    generate
        for (genvar k = 0; k < EXT_SRC; k++) begin : g_src
            // R3
            strobe_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
                evt_in[k] |=> pend[k]);
            // R4
            pending_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[k]) |-> $past(evt_in[k]));
        end
    endgenerate

    // R9
    match_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend[FRAME_SRC]) |-> $past(frame_tick));

    // R8
    tick_advances_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !cnt_load) |=> (count == $past(count) + CNT_W'(1)));

    // R10
    read_valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R7
    ctl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(req_addr == ADDR_W'(OFS_CTL))) |-> (rd_data[SRC_BASE-1:0] == '0));

    // R6
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|evt_in || frame_tick || (req_valid && req_write)));
endmodule

bind frame_irq_ctrl frame_irq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .evt_in     (evt_in),
    .frame_tick (frame_tick),
    .irq        (irq),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .pend       (pend_q),
    .count      (count_q)
);

// File: tb/test_frame_irq_ctrl.sv
module test_frame_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [6:0]  evt_in = '0;
    logic        frame_tick = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";

    // behavioural reference state
    bit          m_en[8];
    bit          m_pend[8];
    logic [31:0] m_cnt, m_match, m_rd;
    bit          m_rv;

    always #4 clk = ~clk;

    frame_irq_ctrl i_frame_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .evt_in(evt_in), .frame_tick(frame_tick), .irq(irq)
    );

    function automatic logic [31:0] m_ctl();
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) begin
            w[17 + 2*k] = m_en[k];
            w[16 + 2*k] = m_pend[k];
        end
        return w;
    endfunction

    function automatic bit m_irq();
        for (int k = 0; k < 8; k++) if (m_en[k] && m_pend[k]) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) begin m_en[k] = 0; m_pend[k] = 0; end
            m_cnt = 0; m_match = 0; m_rd = 0; m_rv = 0;
        end else begin
            logic [31:0] old_match;
            old_match = m_match;
            m_rv = req_valid && !req_write;
            m_rd = 0;
            if (m_rv) begin
                if (req_addr == 8'h00) m_rd = m_ctl();
                else if (req_addr == 8'h40) m_rd = m_cnt;
                else if (req_addr == 8'h50) m_rd = m_match;
            end
            if (req_valid && req_write && req_addr == 8'h00) begin
                for (int k = 0; k < 8; k++) begin
                    m_en[k] = req_wdata[17 + 2*k];
                    if (req_wdata[16 + 2*k]) m_pend[k] = 0;
                end
            end
            for (int k = 0; k < 7; k++) if (evt_in[k]) m_pend[k] = 1;
            if (req_valid && req_write && req_addr == 8'h40) begin
                m_cnt = req_wdata;
            end else if (frame_tick) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == old_match) m_pend[7] = 1;
            end
            if (req_valid && req_write && req_addr == 8'h50) m_match = req_wdata;
        end
    end

    always @(posedge clk) begin
        #2;
        n_cmp++;
        if (irq !== m_irq()) begin
            n_bad++;
            $display("FAIL %s irq got %0b exp %0b at %0t", tag, irq, m_irq(), $time);
        end
        n_cmp++;
        if (rd_valid !== m_rv) begin
            n_bad++;
            $display("FAIL R10 rd_valid got %0b exp %0b at %0t", rd_valid, m_rv, $time);
        end
        n_cmp++;
        if (rd_data !== m_rd) begin
            n_bad++;
            $display("FAIL %s rd_data got %h exp %h at %0t", tag, rd_data, m_rd, $time);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [7:0] a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
    endtask

    task automatic strobe(logic [6:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_tick = 1;
            @(negedge clk);
            frame_tick = 0;
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk); rst_n = 1;
        rd(8'h00); rd(8'h40); rd(8'h50);

        // R2 / R3: each strobe alone, source disabled, then read back its pair
        tag = "R2";
        for (int k = 0; k < 7; k++) begin
            strobe(7'(1 << k));
            rd(8'h00);
            wr(8'h00, 32'h5555_0000);
        end
        tag = "R3";
        strobe(7'h55);
        rd(8'h00);

        // R6: enable sources, irq follows enable & pending
        tag = "R6";
        wr(8'h00, 32'hAAAA_0000);
        rd(8'h00);
        wr(8'h00, 32'h0000_0000);
        idle(2);
        wr(8'h00, 32'h0008_0000);
        idle(2);

        // R4: writing zero to pending bits leaves them; ones clear
        tag = "R4";
        strobe(7'h7F);
        wr(8'h00, 32'hAAAA_0000);
        rd(8'h00);
        wr(8'h00, 32'hAAAA_1111 | 32'h0001_0000 | 32'h0400_0000);
        rd(8'h00);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00);

        // R5: strobe and clear same cycle
        tag = "R5";
        @(negedge clk);
        evt_in = 7'h12; req_valid = 1; req_write = 1; req_addr = 8'h00; req_wdata = 32'hFFFF_0000;
        @(negedge clk);
        evt_in = '0; req_valid = 0; req_write = 0;
        rd(8'h00);

        // R7: low half ignored
        tag = "R7";
        wr(8'h00, 32'h0000_FFFF);
        rd(8'h00);

        // R8: count, load, wrap, load beats tick
        tag = "R8";
        wr(8'h50, 32'h1234_0000);
        ticks(3);
        rd(8'h40);
        wr(8'h40, 32'hFFFF_FFFE);
        ticks(3);
        rd(8'h40);
        @(negedge clk);
        frame_tick = 1; req_valid = 1; req_write = 1; req_addr = 8'h40; req_wdata = 32'h0000_0100;
        @(negedge clk);
        frame_tick = 0; req_valid = 0; req_write = 0;
        rd(8'h40);

        // R9: match raises bit 30; a load onto the match value does not
        tag = "R9";
        wr(8'h00, 32'h8000_FFFF | 32'hFFFF_0000);
        wr(8'h00, 32'h8000_0000);
        wr(8'h40, 32'd2);
        wr(8'h50, 32'd5);
        ticks(2);
        rd(8'h00);
        ticks(1);
        rd(8'h00);
        idle(2);
        wr(8'h00, 32'hC000_0000);
        wr(8'h40, 32'd5);
        rd(8'h00);
        ticks(1);
        rd(8'h50);

        // R10: unmapped addresses
        tag = "R10";
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h44, 32'h0000_0007);
        rd(8'h20); rd(8'h60); rd(8'h44);
        rd(8'h40); rd(8'h00);
        idle(4);
        finish_run();
    end
endmodule